// File: doc/BRIEF.md
# Event Counter and Watchdog with a Switchable Prescaler

This block holds an 8-bit event counter and a watchdog timer. The two share a single 8-bit prescaler, and a 6-bit mode word controls all three. The counter advances on one of two sources. The first is every clock cycle, where each clock is one instruction cycle. The second is a chosen edge of an external pin, which is brought into the clock domain through two flops. The mode word hands the prescaler to one side at a time. When the counter owns it, a ratio code `k` divides counter events by 2^(k+1). When the watchdog owns it, the same code divides watchdog overflows by 2^k, and the counter then moves once per event.

The watchdog is a `WDT_BITS`-wide base counter. It advances on a timebase strobe, `wdt_tick`, and its rollover either passes straight to the reset logic or goes through the prescaler. When enabled, the final overflow raises a one-cycle reset request. Software can load the counter at any time and can restart the watchdog with a clear strobe. The counter keeps its value through the block's own reset, so a program can find it again after a watchdog reset.

Top module: `tmrwd_core`

## Requirements
- R1: After `rst`, the mode word is 6'b111111. Counting therefore follows falling pin edges with no division, and watchdog overflows are divided by 128.
- R2: With mode bit 5 = 0 (clock source) and bit 3 = 0 (prescaler on counter), a ratio code k in bits 2:0 makes the counter advance once every 2^(k+1) clock cycles, counted from the last counter write.
- R3: With mode bit 3 = 1, the counter advances once per source event whatever the ratio code. Watchdog base overflows are divided by 2^k, so a reset request follows 2^WDT_BITS * 2^k timebase ticks.
- R4: With mode bit 5 = 1, the counter follows the pin. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The other edge has no effect. A pin change updates the counter on the third rising clock edge after it.
- R5: A counter write loads `cnt_wdata`, takes priority over an increment in the same cycle, and empties the prescaler.
- R6: The counter wraps from 8'hFF to 8'h00.
- R7: The counter keeps its value through `rst`, and writes are ignored while `rst` is high.
- R8: `wdt_clear` restarts the watchdog base count. When the prescaler belongs to the watchdog, it also empties the prescaler.
- R9: With the prescaler on the counter, a reset request follows every 2^WDT_BITS ticks. `wdt_rst` is high for exactly one cycle and never rises while `wdt_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word: [5] pin source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cnt_rdata | output | 8 | Current counter value |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_en | input | 1 | Watchdog reset enable |
| wdt_tick | input | 1 | Watchdog timebase strobe |
| wdt_clear | input | 1 | Watchdog restart strobe |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The counter path is swept over all eight ratio codes with the prescaler on the counter. Each code is sampled one cycle before and at the expected step, which separates every divisor from its neighbours. The same sweep with the prescaler on the watchdog shows that the code then leaves the counter undivided and scales the watchdog instead. Pin-driven counting uses single pulses, sampled two and three cycles after each transition, under both edge selections; this tells apart the edge polarity and the synchronizer latency. A longer pulse train runs through a divided prescaler, and a counter write is placed in the middle of a partly filled prescaler. The watchdog is counted out tick by tick for every code, with clears placed just before expiry and with the enable low.

// File: rtl/tmrwd_pkg.sv
package tmrwd_pkg;
    localparam int CNT_W   = 8;
    localparam int PRE_W   = 8;
    localparam int RATIO_W = 3;
    localparam int MODE_W  = RATIO_W + 3;
    localparam int SH_W    = $clog2(PRE_W + 1);

    typedef struct packed {
        logic               src_pin;
        logic               fall_edge;
        logic               pre_wdt;
        logic [RATIO_W-1:0] ratio;
    } mode_t;

    localparam mode_t MODE_RST = mode_t'({MODE_W{1'b1}});

    // number of low prescaler bits that must roll over before a pulse passes
    function automatic logic [SH_W-1:0] div_shift(mode_t m);
        logic [SH_W-1:0] s;
        s = SH_W'(m.ratio);
        return m.pre_wdt ? s : s + 1'b1;
    endfunction
endpackage

// File: rtl/tmrwd_pin_edge.sv
module tmrwd_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // [0] first sync flop, [1] second sync flop, [2] previous synced value
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        sh_q <= {sh_q[1:0], pin};
    end

    assign rise = sh_q[1] & ~sh_q[2];
    assign fall = ~sh_q[1] & sh_q[2];

    // R4
    rise_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/tmrwd_prescale.sv
module tmrwd_prescale #(
    parameter int PRE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        evt,
    input  logic [$clog2(PRE_W+1)-1:0]  shift,
    output logic                        fire
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_nx;
    logic [PRE_W-1:0] mask;

    always_comb begin
        pre_nx = pre_q + 1'b1;
        mask   = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(shift)) mask[i] = 1'b1;
        end
    end

    assign fire = evt & ~clr & ((pre_nx & mask) == '0);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (evt)    pre_q <= pre_nx;
    end

    // R5
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pre_q == '0));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/tmrwd_wdt_base.sv
module tmrwd_wdt_base #(
    parameter int WDT_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic ovf
);
    logic [WDT_BITS-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst || clr) base_q <= '0;
        else if (tick)  base_q <= base_q + 1'b1;
    end

    assign ovf = tick & ~clr & (&base_q);

    // R8
    clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ovf);
endmodule

// File: rtl/tmrwd_core.sv
module tmrwd_core
    import tmrwd_pkg::*;
#(
    parameter int WDT_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rdata,
    input  logic              ext_pin,
    input  logic              wdt_en,
    input  logic              wdt_tick,
    input  logic              wdt_clear,
    output logic              wdt_rst
);
    mode_t            mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pin_rise, pin_fall;
    logic             src_evt;
    logic             pre_evt, pre_clr, pre_fire;
    logic             wdt_ovf, wdt_final;
    logic             cnt_inc;
    logic             wdt_rst_q;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MODE_RST;
        else if (mode_we) mode_q <= mode_t'(mode_wdata);
    end

    tmrwd_pin_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    tmrwd_wdt_base #(.WDT_BITS(WDT_BITS)) u_wbase (
        .clk  (clk),
        .rst  (rst),
        .clr  (wdt_clear),
        .tick (wdt_tick),
        .ovf  (wdt_ovf)
    );

    always_comb begin
        if (mode_q.src_pin) src_evt = mode_q.fall_edge ? pin_fall : pin_rise;
        else                src_evt = 1'b1;
        pre_evt = mode_q.pre_wdt ? wdt_ovf : (src_evt & ~rst);
        pre_clr = cnt_we | (wdt_clear & mode_q.pre_wdt);
    end

    tmrwd_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .evt   (pre_evt),
        .shift (div_shift(mode_q)),
        .fire  (pre_fire)
    );

    assign cnt_inc   = ~rst & (mode_q.pre_wdt ? src_evt : pre_fire);
    assign wdt_final = mode_q.pre_wdt ? pre_fire : wdt_ovf;

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (cnt_we)       cnt_q <= cnt_wdata;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wdt_rst_q <= 1'b0;
        else     wdt_rst_q <= wdt_en & wdt_final;
    end

    assign cnt_rdata = cnt_q;
    assign wdt_rst   = wdt_rst_q;

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1 && cnt_inc && !cnt_we) |=> (cnt_q == '0));
    // R5
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_q == $past(cnt_wdata)));
    // R3
    undivided_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q.pre_wdt && src_evt && !cnt_we && !mode_we)
            |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);
    // R9
    rst_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !wdt_rst);
endmodule

// File: tb/tb_tmrwd_core.sv
module tb_tmrwd_core;
    localparam int CLK_PERIOD = 10;
    localparam int WB = 3;
    localparam int BASE = 1 << WB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       ext_pin = 1'b0;
    logic       wdt_en = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clear = 1'b0;
    logic       wdt_rst;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmrwd_core #(.WDT_BITS(WB)) dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .ext_pin(ext_pin), .wdt_en(wdt_en), .wdt_tick(wdt_tick),
        .wdt_clear(wdt_clear), .wdt_rst(wdt_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [5:0] m);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wclear();
        wdt_clear = 1'b1;
        @(negedge clk);
        wdt_clear = 1'b0;
    endtask

    task automatic ticks(input int n, output int seen, output int last);
        seen = 0; last = 0;
        for (int i = 0; i < n; i++) begin
            wdt_tick = 1'b1;
            @(negedge clk);
            wdt_tick = 1'b0;
            last = int'(wdt_rst);
            if (wdt_rst) seen++;
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; cyc(4);
            ext_pin = 1'b0; cyc(4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seen, last;
        cyc(3);
        rst = 1'b0;
        chk("R1 reset request low", int'(wdt_rst), 0);

        // R1: reset mode -> watchdog divided by 128
        wdt_en = 1'b1;
        ticks(BASE*128 - 1, seen, last);
        chk("R1 no early watchdog", seen, 0);
        ticks(1, seen, last);
        chk("R1 watchdog at 1024 ticks", last, 1);
        cyc(1);
        chk("R9 one-cycle pulse", int'(wdt_rst), 0);
        wdt_en = 1'b0;

        // R1: reset mode -> falling pin edges, undivided
        wr_cnt(8'd0);
        ext_pin = 1'b1; cyc(5);
        chk("R1 rising edge ignored", int'(cnt_rdata), 0);
        ext_pin = 1'b0; cyc(5);
        chk("R1 falling edge counted", int'(cnt_rdata), 1);

        // R2: clock source, prescaler on counter
        for (int k = 0; k < 8; k++) begin
            int n;
            n = 2 << k;
            wr_mode({3'b000, 3'(k)});
            wr_cnt(8'd0);
            cyc(3*n - 1);
            chk($sformatf("R2 code %0d before step", k), int'(cnt_rdata), 2);
            cyc(1);
            chk($sformatf("R2 code %0d at step", k), int'(cnt_rdata), 3);
        end

        // R3: prescaler on watchdog leaves counter undivided
        for (int k = 0; k < 8; k++) begin
            wr_mode({3'b001, 3'(k)});
            wr_cnt(8'd10);
            cyc(5);
            chk($sformatf("R3 code %0d undivided", k), int'(cnt_rdata), 15);
        end

        // R6: wrap
        wr_mode(6'b001000);
        wr_cnt(8'hFE);
        cyc(1);
        chk("R6 reaches FF", int'(cnt_rdata), 255);
        cyc(1);
        chk("R6 wraps to 00", int'(cnt_rdata), 0);

        // R5: write wins over increment, write empties prescaler
        wr_cnt(8'd7);
        chk("R5 write wins", int'(cnt_rdata), 7);
        wr_mode(6'b000010);
        wr_cnt(8'd0);
        cyc(6);
        wr_cnt(8'd40);
        cyc(7);
        chk("R5 prescaler emptied", int'(cnt_rdata), 40);
        cyc(1);
        chk("R5 first step after write", int'(cnt_rdata), 41);

        // R4: pin source, both polarities, latency
        for (int e = 0; e < 2; e++) begin
            wr_mode({1'b1, 1'(e), 1'b1, 3'b000});
            wr_cnt(8'd0);
            ext_pin = 1'b1;
            cyc(2);
            chk($sformatf("R4 edge%0d rise +2", e), int'(cnt_rdata), 0);
            cyc(1);
            chk($sformatf("R4 edge%0d rise +3", e), int'(cnt_rdata), (e == 0) ? 1 : 0);
            cyc(3);
            ext_pin = 1'b0;
            cyc(2);
            chk($sformatf("R4 edge%0d fall +2", e), int'(cnt_rdata), (e == 0) ? 1 : 0);
            cyc(1);
            chk($sformatf("R4 edge%0d fall +3", e), int'(cnt_rdata), 1);
            cyc(3);
            pulses(5);
            chk($sformatf("R4 edge%0d train", e), int'(cnt_rdata), 6);
        end

        // R4/R2: pin source through divide-by-4
        wr_mode(6'b100001);
        wr_cnt(8'd0);
        pulses(8);
        chk("R4 divided pin count", int'(cnt_rdata), 2);
        pulses(11);
        chk("R4 divided pin remainder", int'(cnt_rdata), 4);

        // R7: counter survives reset, writes ignored in reset
        wr_mode(6'b100000);
        wr_cnt(8'h5A);
        rst = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'h00;
        cyc(3);
        rst = 1'b0; cnt_we = 1'b0;
        cyc(1);
        chk("R7 counter retained", int'(cnt_rdata), 90);

        // R3: watchdog division sweep
        wdt_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            int d;
            d = BASE << k;
            wr_mode({3'b001, 3'(k)});
            wclear();
            ticks(d - 1, seen, last);
            chk($sformatf("R3 wdt code %0d early", k), seen, 0);
            ticks(1, seen, last);
            chk($sformatf("R3 wdt code %0d expiry", k), last, 1);
        end

        // R8: clear restarts base and prescaler
        wr_mode(6'b001010);
        wclear();
        ticks(BASE*4 - 2, seen, last);
        wclear();
        ticks(BASE*4 - 1, seen, last);
        chk("R8 clear postpones expiry", seen, 0);
        ticks(1, seen, last);
        chk("R8 expiry after clear", last, 1);

        // R9: prescaler on counter -> watchdog undivided
        wr_mode(6'b000000);
        wclear();
        ticks(BASE - 1, seen, last);
        wclear();
        ticks(BASE - 1, seen, last);
        chk("R9/R8 base-only clear", seen, 0);
        ticks(1, seen, last);
        chk("R9 undivided expiry", last, 1);

        // R9: disabled watchdog never requests
        wdt_en = 1'b0;
        ticks(BASE*8, seen, last);
        chk("R9 disabled no request", seen, 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule